// File: doc/BRIEF.md
# Buffer Descriptor Ring Engine

This block walks two rings of buffer descriptors, one for transmit and one for receive. Both rings are held in a small memory inside the block. Each descriptor holds a 16-bit status word, a 16-bit length and a buffer pointer. Software fills descriptors through a host write port and reads them back through a read port. Ownership passes between software and the engine through a single ownership bit in each status word.

On the transmit side, the engine looks at the descriptor under its index. If that descriptor belongs to hardware, the engine presents the descriptor's pointer, length and frame flags as a transfer request. It holds the request until the MAC signals that the frame is done. It then hands the descriptor back and moves to the next one. On the receive side, each incoming frame goes into the descriptor under the receive index: the engine stores the length and error code there and returns the descriptor to software.

Each side stops when it meets a descriptor it does not own, and waits for an explicit clear-halt pulse. A graceful stop request lets a frame already in flight finish. Busy and stop-complete conditions are latched in event bits that software clears by writing one to them.

Top module: `bdr_engine`

## Requirements
- R1: After reset or an `init` pulse: each index equals its ring base (zero after reset), and both sides are halted. Every receive status reads 0x8000 (bit 15 = owned by hardware) with length 0, every transmit status reads 0x0000, and the last descriptor of each ring also has bit 13 (wrap) set. An `init` pulse leaves buffer pointers and events unchanged; reset clears them.
- R2: When the transmitter is running, no stop is requested, and the current descriptor has bit 15 (ready) set, `tx_req_valid` rises at the next edge. The request carries that descriptor's pointer and length, plus `tx_req_flags` = {bit 12 interrupt, bit 11 last, bit 10 append-CRC}. All of these stay stable until `tx_done`.
- R3: At the edge where `tx_done` is seen with a request pending, `tx_req_valid` falls. Bit 15 of that descriptor is cleared, its other status bits are kept, and the transmit index advances.
- R4: After a descriptor is consumed, the index returns to the ring base if that descriptor has bit 13 set, and otherwise increments by one.
- R5: A running transmitter that finds a descriptor without bit 15 sets `tx_halted`. While halted, it starts no frame. After a `tx_clr_halt` pulse it resumes with the same descriptor.
- R6: A received frame landing on a descriptor with bit 15 set stores `rx_len` unchanged (this count includes the 4-byte frame check sequence) and places `rx_err` in status bits [5:0]. Bit 15 is cleared, bit 13 is kept, and the receive index advances.
- R7: A frame with a nonzero error code still consumes its descriptor, exactly as a good frame does.
- R8: A frame that meets a descriptor without bit 15 sets event bit 0 (busy) and `rx_halted`, and the frame is dropped. Frames arriving while halted are dropped without effect. A `rx_clr_halt` pulse resumes reception at the same index.
- R9: While `tx_stop_req` is high, a frame already requested completes normally, and no new frame starts. Event bit 2 is set at the first edge where the transmitter is idle with the request high.
- R10: Event bit 1 is set at the first edge where `rx_stop_req` is high. Frames arriving while it stays high are ignored.
- R11: Event bits are sticky. A 1 in the matching bit of `evt_clr` clears them, and a 0 leaves them set.
- R12: A `base_we` write sets the ring base for the ring selected by `base_ring` (0 transmit, 1 receive). The new base is used by later `init` pulses and by wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| init | input | 1 | Re-initialise rings and indices |
| host_we | input | 1 | Host descriptor write |
| host_ring | input | 1 | Ring selected for host write (0 tx, 1 rx) |
| host_idx | input | 3 | Descriptor index for host write |
| host_st | input | 16 | Status word to write |
| host_len | input | 16 | Length to write |
| host_ptr | input | 32 | Buffer pointer to write |
| rd_ring | input | 1 | Ring selected for readback |
| rd_idx | input | 3 | Descriptor index for readback |
| rd_st | output | 16 | Status word read back |
| rd_len | output | 16 | Length read back |
| rd_ptr | output | 32 | Pointer read back |
| base_we | input | 1 | Ring base write |
| base_ring | input | 1 | Ring selected for base write |
| base_idx | input | 3 | New ring base |
| tx_clr_halt | input | 1 | Clear transmit halt |
| rx_clr_halt | input | 1 | Clear receive halt |
| tx_stop_req | input | 1 | Graceful transmit stop request |
| rx_stop_req | input | 1 | Graceful receive stop request |
| evt_clr | input | 3 | Write-one-to-clear for events |
| evt | output | 3 | Events: [0] busy, [1] rx stopped, [2] tx stopped |
| tx_halted | output | 1 | Transmitter halted |
| rx_halted | output | 1 | Receiver halted |
| tx_req_valid | output | 1 | Transfer request pending |
| tx_req_ptr | output | 32 | Request buffer pointer |
| tx_req_len | output | 16 | Request length |
| tx_req_flags | output | 3 | {interrupt, last, append-CRC} |
| tx_done | input | 1 | Requested frame has been sent |
| rx_valid | input | 1 | A received frame needs a descriptor |
| rx_len | input | 16 | Received length including FCS |
| rx_err | input | 6 | Receive error code |

## Verification
The bench targets several corner cases, each with the failure it would expose:
- Wrap: the index must return to a nonzero ring base after the last descriptor. A design that wrapped to zero would store the next frame into an owned descriptor instead of raising busy.
- Graceful transmit stop: the stop is requested mid-frame. A design that signalled completion too early would set bit 2 before `tx_done`. One that ignored the stop would issue the next ready descriptor.
- Receive overflow and halt: a full receive ring with a frame arriving while halted. A design that failed to drop such frames would overwrite descriptor zero.
- Bad frame: a frame with a nonzero error code must still consume its descriptor. A design that skipped it would leave it owned and shift later frames to the wrong slot.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  localparam int OWN_B  = 15;
  localparam int WRAP_B = 13;
  localparam int INT_B  = 12;
  localparam int LAST_B = 11;
  localparam int CRC_B  = 10;

  // status word a descriptor takes on at reset or init
  function automatic logic [15:0] fresh_status(logic own, logic last);
    logic [15:0] s;
    s = '0;
    s[OWN_B]  = own;
    s[WRAP_B] = last;
    return s;
  endfunction

  // index that follows a consumed descriptor
  function automatic int unsigned ring_next(int unsigned idx, logic wrap,
                                            int unsigned base, int unsigned depth);
    return wrap ? base : ((idx + 1) % depth);
  endfunction

  // status of a receive descriptor once a frame lands in it
  function automatic logic [15:0] rx_fill(logic [15:0] old, logic [15:0] err,
                                          logic [15:0] mask);
    return (old & ~mask & ~(16'h1 << OWN_B)) | (err & mask);
  endfunction
endpackage

// File: rtl/bdr_store.sv
module bdr_store
  import bdr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = 32,
  parameter bit OWN_INIT = 1'b0,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             h_we,
  input  logic [IW-1:0]    h_idx,
  input  logic [15:0]      h_st,
  input  logic [15:0]      h_len,
  input  logic [PTR_W-1:0] h_ptr,
  input  logic             e_we,
  input  logic [IW-1:0]    e_idx,
  input  logic [15:0]      e_st,
  input  logic [15:0]      e_len,
  input  logic [IW-1:0]    a_idx,
  output logic [15:0]      a_st,
  output logic [15:0]      a_len,
  output logic [PTR_W-1:0] a_ptr,
  input  logic [IW-1:0]    b_idx,
  output logic [15:0]      b_st,
  output logic [15:0]      b_len,
  output logic [PTR_W-1:0] b_ptr
);
  logic [15:0]      st_q  [DEPTH];
  logic [15:0]      len_q [DEPTH];
  logic [PTR_W-1:0] ptr_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i]  <= fresh_status(OWN_INIT, i == DEPTH - 1);
        len_q[i] <= '0;
        ptr_q[i] <= '0;
      end
    end else if (init) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i]  <= fresh_status(OWN_INIT, i == DEPTH - 1);
        len_q[i] <= '0;
      end
    end else begin
      if (h_we) begin
        st_q[h_idx]  <= h_st;
        len_q[h_idx] <= h_len;
        ptr_q[h_idx] <= h_ptr;
      end
      // the engine's update wins over a host write to the same entry
      if (e_we) begin
        st_q[e_idx]  <= e_st;
        len_q[e_idx] <= e_len;
      end
    end
  end

  assign a_st  = st_q[a_idx];
  assign a_len = len_q[a_idx];
  assign a_ptr = ptr_q[a_idx];
  assign b_st  = st_q[b_idx];
  assign b_len = len_q[b_idx];
  assign b_ptr = ptr_q[b_idx];
endmodule

// File: rtl/bdr_tx_seq.sv
module bdr_tx_seq
  import bdr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic [IW-1:0] base,
  input  logic          clr_halt,
  input  logic          stop_req,
  input  logic [15:0]   cur_st,
  input  logic          done,
  output logic [IW-1:0] idx,
  output logic          req_valid,
  output logic          e_we,
  output logic [15:0]   e_st,
  output logic          halted,
  output logic          stop_pulse
);
  typedef enum logic {TX_IDLE, TX_WAIT} tx_state_e;
  tx_state_e     state_q;
  logic [IW-1:0] idx_q;
  logic          halted_q, stopped_q;
  logic          idle;

  assign idle       = (state_q == TX_IDLE);
  assign stop_pulse = !init && stop_req && idle && !stopped_q;
  assign e_we       = !init && !idle && done;
  assign e_st       = cur_st & ~(16'h1 << OWN_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= TX_IDLE;
      idx_q     <= '0;
      halted_q  <= 1'b1;
      stopped_q <= 1'b0;
    end else if (init) begin
      state_q   <= TX_IDLE;
      idx_q     <= base;
      halted_q  <= 1'b1;
      stopped_q <= 1'b0;
    end else begin
      stopped_q <= stop_req && idle;
      if (idle) begin
        if (clr_halt && halted_q) halted_q <= 1'b0;
        else if (!halted_q && !stop_req) begin
          if (cur_st[OWN_B]) state_q <= TX_WAIT;
          else halted_q <= 1'b1;
        end
      end else if (done) begin
        state_q <= TX_IDLE;
        idx_q   <= IW'(ring_next(32'(idx_q), cur_st[WRAP_B], 32'(base), DEPTH));
      end
    end
  end

  assign idx       = idx_q;
  assign req_valid = !idle;
  assign halted    = halted_q;
endmodule

// File: rtl/bdr_rx_seq.sv
module bdr_rx_seq
  import bdr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ERR_W = 6,
  localparam int IW = $clog2(DEPTH),
  localparam logic [15:0] ERR_MASK = 16'((1 << ERR_W) - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic [IW-1:0]    base,
  input  logic             clr_halt,
  input  logic             stop_req,
  input  logic [15:0]      cur_st,
  input  logic             frm_valid,
  input  logic [15:0]      frm_len,
  input  logic [ERR_W-1:0] frm_err,
  output logic [IW-1:0]    idx,
  output logic             e_we,
  output logic [15:0]      e_st,
  output logic [15:0]      e_len,
  output logic             halted,
  output logic             stop_pulse,
  output logic             busy_pulse
);
  logic [IW-1:0] idx_q;
  logic          halted_q, stopped_q;
  logic          take;

  assign take       = !init && frm_valid && !halted_q && !stop_req;
  assign e_we       = take && cur_st[OWN_B];
  assign busy_pulse = take && !cur_st[OWN_B];
  assign stop_pulse = !init && stop_req && !stopped_q;
  assign e_st       = rx_fill(cur_st, 16'(frm_err), ERR_MASK);
  assign e_len      = frm_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      halted_q  <= 1'b1;
      stopped_q <= 1'b0;
    end else if (init) begin
      idx_q     <= base;
      halted_q  <= 1'b1;
      stopped_q <= 1'b0;
    end else begin
      stopped_q <= stop_req;
      if (clr_halt && halted_q) halted_q <= 1'b0;
      else if (busy_pulse) halted_q <= 1'b1;
      if (e_we)
        idx_q <= IW'(ring_next(32'(idx_q), cur_st[WRAP_B], 32'(base), DEPTH));
    end
  end

  assign idx    = idx_q;
  assign halted = halted_q;
endmodule

// File: rtl/bdr_engine.sv
module bdr_engine
  import bdr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = 32,
  parameter int ERR_W = 6,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             host_we,
  input  logic             host_ring,
  input  logic [IW-1:0]    host_idx,
  input  logic [15:0]      host_st,
  input  logic [15:0]      host_len,
  input  logic [PTR_W-1:0] host_ptr,
  input  logic             rd_ring,
  input  logic [IW-1:0]    rd_idx,
  output logic [15:0]      rd_st,
  output logic [15:0]      rd_len,
  output logic [PTR_W-1:0] rd_ptr,
  input  logic             base_we,
  input  logic             base_ring,
  input  logic [IW-1:0]    base_idx,
  input  logic             tx_clr_halt,
  input  logic             rx_clr_halt,
  input  logic             tx_stop_req,
  input  logic             rx_stop_req,
  input  logic [2:0]       evt_clr,
  output logic [2:0]       evt,
  output logic             tx_halted,
  output logic             rx_halted,
  output logic             tx_req_valid,
  output logic [PTR_W-1:0] tx_req_ptr,
  output logic [15:0]      tx_req_len,
  output logic [2:0]       tx_req_flags,
  input  logic             tx_done,
  input  logic             rx_valid,
  input  logic [15:0]      rx_len,
  input  logic [ERR_W-1:0] rx_err
);
  // per ring: index 0 transmit, index 1 receive
  logic [IW-1:0]    base_q  [2];
  logic [IW-1:0]    eng_idx [2];
  logic             eng_we  [2];
  logic [15:0]      eng_st  [2];
  logic [15:0]      eng_len [2];
  logic [15:0]      cur_st  [2];
  logic [15:0]      cur_len [2];
  logic [PTR_W-1:0] cur_ptr [2];
  logic [15:0]      rb_st   [2];
  logic [15:0]      rb_len  [2];
  logic [PTR_W-1:0] rb_ptr  [2];

  // named internal events, visible to the checker
  logic tx_stop_w, rx_stop_w, rx_busy_w;
  logic [2:0] evt_q;

  for (genvar r = 0; r < 2; r++) begin : g_ring
    bdr_store #(.DEPTH(DEPTH), .PTR_W(PTR_W), .OWN_INIT(r == 1)) u_store (
      .clk(clk), .rst_n(rst_n), .init(init),
      .h_we(host_we && (host_ring == 1'(r))), .h_idx(host_idx),
      .h_st(host_st), .h_len(host_len), .h_ptr(host_ptr),
      .e_we(eng_we[r]), .e_idx(eng_idx[r]), .e_st(eng_st[r]), .e_len(eng_len[r]),
      .a_idx(eng_idx[r]), .a_st(cur_st[r]), .a_len(cur_len[r]), .a_ptr(cur_ptr[r]),
      .b_idx(rd_idx), .b_st(rb_st[r]), .b_len(rb_len[r]), .b_ptr(rb_ptr[r])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) base_q[r] <= '0;
      else if (base_we && (base_ring == 1'(r))) base_q[r] <= base_idx;
    end
  end

  bdr_tx_seq #(.DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .init(init), .base(base_q[0]),
    .clr_halt(tx_clr_halt), .stop_req(tx_stop_req), .cur_st(cur_st[0]),
    .done(tx_done), .idx(eng_idx[0]), .req_valid(tx_req_valid),
    .e_we(eng_we[0]), .e_st(eng_st[0]), .halted(tx_halted), .stop_pulse(tx_stop_w)
  );
  assign eng_len[0] = cur_len[0];

  bdr_rx_seq #(.DEPTH(DEPTH), .ERR_W(ERR_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .init(init), .base(base_q[1]),
    .clr_halt(rx_clr_halt), .stop_req(rx_stop_req), .cur_st(cur_st[1]),
    .frm_valid(rx_valid), .frm_len(rx_len), .frm_err(rx_err),
    .idx(eng_idx[1]), .e_we(eng_we[1]), .e_st(eng_st[1]), .e_len(eng_len[1]),
    .halted(rx_halted), .stop_pulse(rx_stop_w), .busy_pulse(rx_busy_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else evt_q <= (evt_q & ~evt_clr) | {tx_stop_w, rx_stop_w, rx_busy_w};
  end

  assign evt          = evt_q;
  assign tx_req_ptr   = cur_ptr[0];
  assign tx_req_len   = cur_len[0];
  assign tx_req_flags = {cur_st[0][INT_B], cur_st[0][LAST_B], cur_st[0][CRC_B]};
  assign rd_st        = rb_st[rd_ring];
  assign rd_len       = rb_len[rd_ring];
  assign rd_ptr       = rb_ptr[rd_ring];
endmodule

// File: rtl/bdr_engine_chk.sv
module bdr_engine_chk #(
  parameter int PTR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init,
  input logic             host_we,
  input logic             tx_req_valid,
  input logic             tx_done,
  input logic [PTR_W-1:0] tx_req_ptr,
  input logic             tx_halted,
  input logic             rx_halted,
  input logic             rx_clr_halt,
  input logic             rx_busy,
  input logic             tx_stop,
  input logic [2:0]       evt,
  input logic [2:0]       evt_clr
);
  // R2
  tx_req_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_valid |-> !tx_halted);
  // R2
  tx_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_valid && !tx_done && !init && !host_we |=> tx_req_valid && $stable(tx_req_ptr));
  // R3
  tx_done_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_valid && tx_done |=> !tx_req_valid);
  // R8
  rx_busy_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy |=> rx_halted && evt[0]);
  // R8
  rx_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr_halt && rx_halted && !init |=> !rx_halted);
  // R9
  tx_stop_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stop |=> evt[2]);
  // R11
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] && !evt_clr[0] |=> evt[0]);
endmodule

bind bdr_engine bdr_engine_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .init(init), .host_we(host_we),
  .tx_req_valid(tx_req_valid), .tx_done(tx_done), .tx_req_ptr(tx_req_ptr),
  .tx_halted(tx_halted), .rx_halted(rx_halted), .rx_clr_halt(rx_clr_halt),
  .rx_busy(rx_busy_w), .tx_stop(tx_stop_w), .evt(evt), .evt_clr(evt_clr)
);

// File: tb/bdr_engine_test.sv
module bdr_engine_test;
  localparam int D = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 0, host_we = 0, host_ring = 0;
  logic [IW-1:0] host_idx = '0;
  logic [15:0] host_st = '0, host_len = '0;
  logic [31:0] host_ptr = '0;
  logic rd_ring = 0;
  logic [IW-1:0] rd_idx = '0;
  logic [15:0] rd_st, rd_len;
  logic [31:0] rd_ptr;
  logic base_we = 0, base_ring = 0;
  logic [IW-1:0] base_idx = '0;
  logic tx_clr_halt = 0, rx_clr_halt = 0, tx_stop_req = 0, rx_stop_req = 0;
  logic [2:0] evt_clr = '0, evt;
  logic tx_halted, rx_halted, tx_req_valid;
  logic [31:0] tx_req_ptr;
  logic [15:0] tx_req_len;
  logic [2:0] tx_req_flags;
  logic tx_done = 0, rx_valid = 0;
  logic [15:0] rx_len = '0;
  logic [5:0] rx_err = '0;

  int total = 0, fails = 0;

  always #4 clk = ~clk;

  bdr_engine uut (
    .clk(clk), .rst_n(rst_n), .init(init), .host_we(host_we), .host_ring(host_ring),
    .host_idx(host_idx), .host_st(host_st), .host_len(host_len), .host_ptr(host_ptr),
    .rd_ring(rd_ring), .rd_idx(rd_idx), .rd_st(rd_st), .rd_len(rd_len), .rd_ptr(rd_ptr),
    .base_we(base_we), .base_ring(base_ring), .base_idx(base_idx),
    .tx_clr_halt(tx_clr_halt), .rx_clr_halt(rx_clr_halt),
    .tx_stop_req(tx_stop_req), .rx_stop_req(rx_stop_req),
    .evt_clr(evt_clr), .evt(evt), .tx_halted(tx_halted), .rx_halted(rx_halted),
    .tx_req_valid(tx_req_valid), .tx_req_ptr(tx_req_ptr), .tx_req_len(tx_req_len),
    .tx_req_flags(tx_req_flags), .tx_done(tx_done),
    .rx_valid(rx_valid), .rx_len(rx_len), .rx_err(rx_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_st  [2][D];
  logic [15:0] m_len [2][D];
  logic [31:0] m_ptr [2][D];
  int m_tidx, m_ridx, m_tbase, m_rbase;
  bit m_thalt, m_rhalt, m_twait, m_tsq, m_rsq;
  bit [2:0] m_evt;

  task automatic m_fresh();
    for (int i = 0; i < D; i++) begin
      m_st[0][i] = (i == D - 1) ? 16'h2000 : 16'h0000;
      m_st[1][i] = (i == D - 1) ? 16'hA000 : 16'h8000;
      m_len[0][i] = 0;
      m_len[1][i] = 0;
    end
    m_tidx = m_tbase; m_ridx = m_rbase;
    m_thalt = 1; m_rhalt = 1; m_twait = 0; m_tsq = 0; m_rsq = 0;
  endtask

  always @(posedge clk) begin
    bit [2:0] set;
    bit t_idle, r_take, r_own, tsq_n;
    logic [15:0] old_t, old_r;
    if (!rst_n) begin
      m_tbase = 0; m_rbase = 0; m_evt = 0;
      for (int i = 0; i < D; i++) begin m_ptr[0][i] = 0; m_ptr[1][i] = 0; end
      m_fresh();
    end else begin
      t_idle = !m_twait;
      old_t = m_st[0][m_tidx];
      old_r = m_st[1][m_ridx];
      r_own = old_r[15];
      r_take = !init && rx_valid && !m_rhalt && !rx_stop_req;
      set = '0;
      set[2] = !init && tx_stop_req && t_idle && !m_tsq;
      set[1] = !init && rx_stop_req && !m_rsq;
      set[0] = r_take && !r_own;
      if (init) m_fresh();
      else begin
        if (host_we) begin
          m_st[host_ring][host_idx] = host_st;
          m_len[host_ring][host_idx] = host_len;
          m_ptr[host_ring][host_idx] = host_ptr;
        end
        tsq_n = tx_stop_req && t_idle;
        if (t_idle) begin
          if (tx_clr_halt && m_thalt) m_thalt = 0;
          else if (!m_thalt && !tx_stop_req) begin
            if (old_t[15]) m_twait = 1; else m_thalt = 1;
          end
        end else if (tx_done) begin
          m_st[0][m_tidx] = old_t & 16'h7FFF;
          m_len[0][m_tidx] = m_len[0][m_tidx];
          m_twait = 0;
          m_tidx = old_t[13] ? m_tbase : (m_tidx + 1) % D;
        end
        m_tsq = tsq_n;
        if (rx_clr_halt && m_rhalt) m_rhalt = 0;
        else if (set[0]) m_rhalt = 1;
        if (r_take && r_own) begin
          m_st[1][m_ridx] = {1'b0, old_r[14:6], rx_err};
          m_len[1][m_ridx] = rx_len;
          m_ridx = old_r[13] ? m_rbase : (m_ridx + 1) % D;
        end
        m_rsq = rx_stop_req;
      end
      if (base_we) begin
        if (base_ring) m_rbase = base_idx; else m_tbase = base_idx;
      end
      m_evt = (m_evt & ~evt_clr) | set;
    end
  end

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(tx_req_valid == m_twait, "R2 request valid", tx_req_valid, m_twait);
      if (m_twait) begin
        chk(tx_req_ptr == m_ptr[0][m_tidx], "R2 request pointer", tx_req_ptr, m_ptr[0][m_tidx]);
        chk(tx_req_len == m_len[0][m_tidx], "R2 request length", tx_req_len, m_len[0][m_tidx]);
        chk(tx_req_flags == {m_st[0][m_tidx][12], m_st[0][m_tidx][11], m_st[0][m_tidx][10]},
            "R2 request flags", tx_req_flags, m_st[0][m_tidx][12:10]);
      end
      chk(tx_halted == m_thalt, "R5 tx halt", tx_halted, m_thalt);
      chk(rx_halted == m_rhalt, "R8 rx halt", rx_halted, m_rhalt);
      chk(evt == m_evt, "R11 events", evt, m_evt);
      chk(rd_st == m_st[rd_ring][rd_idx] && rd_len == m_len[rd_ring][rd_idx] &&
          rd_ptr == m_ptr[rd_ring][rd_idx], "R6 descriptor readback",
          {rd_st, rd_len, rd_ptr}, {m_st[rd_ring][rd_idx], m_len[rd_ring][rd_idx], m_ptr[rd_ring][rd_idx]});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic hw(input bit ring, input int idx, input logic [15:0] st,
                    input logic [15:0] len, input logic [31:0] ptr);
    host_we = 1; host_ring = ring; host_idx = IW'(idx);
    host_st = st; host_len = len; host_ptr = ptr;
    cyc();
    host_we = 0;
  endtask

  task automatic rx_frame(input logic [15:0] len, input logic [5:0] err);
    rx_valid = 1; rx_len = len; rx_err = err;
    cyc();
    rx_valid = 0;
  endtask

  task automatic look(input bit ring, input int idx, input logic [15:0] est,
                      input logic [15:0] elen, input string tag);
    rd_ring = ring; rd_idx = IW'(idx);
    #1;
    chk(rd_st == est, tag, rd_st, est);
    chk(rd_len == elen, tag, rd_len, elen);
  endtask

  task automatic expect_req(input logic [31:0] ptr, input logic [2:0] fl, input string tag);
    chk(tx_req_valid === 1'b1, tag, tx_req_valid, 1);
    chk(tx_req_ptr == ptr, tag, tx_req_ptr, ptr);
    chk(tx_req_flags == fl, tag, tx_req_flags, fl);
  endtask

  task automatic finish_tx();
    tx_done = 1; cyc(); tx_done = 0;
  endtask

  task automatic pulse_tx_clr(); tx_clr_halt = 1; cyc(); tx_clr_halt = 0; endtask
  task automatic pulse_rx_clr(); rx_clr_halt = 1; cyc(); rx_clr_halt = 0; endtask

  initial begin
    #(8 * 20000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc();
    // R1 reset state
    chk(tx_halted && rx_halted, "R1 both halted after reset", {tx_halted, rx_halted}, 2'b11);
    chk(evt == 0, "R1 events clear", evt, 0);
    look(1, 0, 16'h8000, 0, "R1 rx desc0 empty");
    look(1, 7, 16'hA000, 0, "R1 rx last wrap");
    look(0, 0, 16'h0000, 0, "R1 tx desc0");
    look(0, 7, 16'h2000, 0, "R1 tx last wrap");

    // R2 / R3 transmit in order
    hw(0, 0, 16'h8C00, 100, 32'h1000);
    hw(0, 1, 16'h9C00, 200, 32'h2000);
    hw(0, 2, 16'h8800, 60, 32'h3000);
    pulse_tx_clr();
    chk(!tx_halted, "R5 clear halt", tx_halted, 0);
    cyc();
    expect_req(32'h1000, 3'b011, "R2 first request");
    chk(tx_req_len == 100, "R2 length", tx_req_len, 100);
    finish_tx();
    chk(!tx_req_valid, "R3 request retired", tx_req_valid, 0);
    look(0, 0, 16'h0C00, 100, "R3 ready cleared");
    cyc();
    expect_req(32'h2000, 3'b111, "R2 second request flags");
    finish_tx(); cyc();
    expect_req(32'h3000, 3'b010, "R2 third request");
    finish_tx(); cyc();
    chk(tx_halted, "R5 halt on not-ready", tx_halted, 1);
    cyc(3);
    chk(!tx_req_valid, "R5 no start while halted", tx_req_valid, 0);

    // R4 wrap on the transmit ring
    hw(0, 3, 16'hA000, 10, 32'h4000);
    hw(0, 0, 16'h8000, 20, 32'h5000);
    pulse_tx_clr(); cyc();
    expect_req(32'h4000, 3'b000, "R5 resume same descriptor");
    finish_tx(); cyc();
    expect_req(32'h5000, 3'b000, "R4 wrap to base");
    finish_tx(); cyc();
    chk(tx_halted, "R5 halted at desc1", tx_halted, 1);

    // R9 graceful transmit stop
    hw(0, 1, 16'h8800, 30, 32'h6000);
    hw(0, 2, 16'h8800, 40, 32'h7000);
    pulse_tx_clr(); cyc();
    expect_req(32'h6000, 3'b010, "R9 frame in flight");
    tx_stop_req = 1;
    cyc(2);
    chk(evt[2] == 0, "R9 no stop event mid-frame", evt[2], 0);
    chk(tx_req_valid, "R9 frame continues", tx_req_valid, 1);
    finish_tx();
    chk(evt[2] == 0, "R9 event after idle edge", evt[2], 0);
    cyc();
    chk(evt[2] == 1, "R9 stop complete", evt[2], 1);
    cyc(3);
    chk(!tx_req_valid, "R9 no new frame while stopped", tx_req_valid, 0);
    evt_clr = 3'b100; cyc(); evt_clr = 0;
    chk(evt == 0, "R11 write one clears", evt, 0);
    tx_stop_req = 0;
    cyc(2);
    expect_req(32'h7000, 3'b010, "R9 resume after stop");
    finish_tx(); cyc(2);

    // R6 / R7 receive
    pulse_rx_clr();
    chk(!rx_halted, "R8 rx running", rx_halted, 0);
    rx_frame(64, 0);
    look(1, 0, 16'h0000, 64, "R6 good frame stored");
    rx_frame(1518, 6'h05);
    look(1, 1, 16'h0005, 1518, "R7 bad frame consumed");
    for (int i = 2; i < D; i++) rx_frame(16'(70 + i), 0);
    look(1, 7, 16'h2000, 77, "R6 wrap bit kept");
    rx_frame(300, 0);
    chk(evt[0] == 1, "R8 busy event", evt[0], 1);
    chk(rx_halted, "R8 halted on full ring", rx_halted, 1);
    look(1, 0, 16'h0000, 64, "R8 frame dropped");
    cyc(2);
    chk(evt[0] == 1, "R11 event sticky", evt[0], 1);
    hw(1, 0, 16'h8000, 0, 32'h0);
    rx_frame(301, 0);
    look(1, 0, 16'h8000, 0, "R8 dropped while halted");
    evt_clr = 3'b001; cyc(); evt_clr = 0;
    chk(evt[0] == 0, "R11 busy cleared", evt[0], 0);
    pulse_rx_clr();
    rx_frame(99, 0);
    look(1, 0, 16'h0000, 99, "R8 resume at same index");

    // R10 graceful receive stop
    hw(1, 1, 16'h8000, 0, 32'h0);
    rx_stop_req = 1;
    cyc();
    chk(evt[1] == 1, "R10 rx stop event", evt[1], 1);
    rx_frame(55, 0);
    look(1, 1, 16'h8000, 0, "R10 frame ignored");
    chk(evt[0] == 0, "R10 no busy while stopped", evt[0], 0);
    rx_stop_req = 0;
    evt_clr = 3'b010; cyc(); evt_clr = 0;

    // R12 ring base, R1 init
    base_we = 1; base_ring = 1; base_idx = 3'd2; cyc(); base_we = 0;
    init = 1; cyc(); init = 0;
    chk(tx_halted && rx_halted, "R1 halted after init", {tx_halted, rx_halted}, 2'b11);
    look(1, 2, 16'h8000, 0, "R1 init rx desc");
    look(0, 7, 16'h2000, 0, "R1 init tx last");
    pulse_rx_clr();
    for (int i = 2; i < D; i++) rx_frame(16'(200 + i), 0);
    look(1, 2, 16'h0000, 202, "R12 first frame at base");
    look(1, 7, 16'h2000, 207, "R12 last frame");
    rx_frame(400, 0);
    chk(evt[0] == 1, "R12 wrap returns to base", evt[0], 1);
    look(1, 0, 16'h8000, 0, "R4 desc0 untouched after wrap");

    cyc(2);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule